// File: doc/BRIEF.md
# Forty-Bit Add/Subtract Unit with Selectable Condition Flag

This block adds or subtracts two 40-bit operands and registers both the 40-bit sum and a single condition flag. The meaning of the flag is chosen per operation by a 3-bit select input. The flag can report the sign of the result, a zero result, or an overflow of the 32-bit register field. The remaining select codes report the carry out of an addition or the borrow of a subtraction.

The result is an 8-bit guard field in bits 39:32 above a 32-bit register field in bits 31:0. The arithmetic always runs on the full 40 bits and wraps modulo 2^40, with no saturation. The overflow flag does not use the guard field: it reports whether the value would fit in the 32-bit field alone.

Both outputs change only on a clock edge where the write enable is high. They therefore appear one cycle after the operands are presented.

Top module: `alu_dc_unit`

## Requirements
- R1: A synchronous active-high reset sets the result to 0 and the flag to 0 at the next clock edge.
- R2: When the write enable is high and the subtract select is 0, the result at the next edge is (a + b) mod 2^40.
- R3: When the write enable is high and the subtract select is 1, the result at the next edge is (a - b) mod 2^40.
- R4: With select code 3'b001, the flag equals bit 39 of the new result: 1 for a negative value and 0 for a positive one.
- R5: With select code 3'b010, the flag is 1 exactly when all 40 bits of the new result are zero.
- R6: With select code 3'b011, the flag is 1 exactly when result bits 39 down to 31 are not all equal. For example, 0xFF7FFFFFFF sets the flag and 0xFF80000000 clears it.
- R7: With select codes 3'b000 and 3'b100 to 3'b111 in an addition, the flag is the carry out of bit 39 of the unsigned sum.
- R8: With select codes 3'b000 and 3'b100 to 3'b111 in a subtraction, the flag is 1 exactly when a is less than b, both taken as unsigned 40-bit values.
- R9: When the write enable is low, the result and the flag keep their values, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_we | input | 1 | Execute the operation and update both outputs |
| op_sub | input | 1 | 0 selects add, 1 selects subtract |
| flag_sel | input | 3 | Selects what the condition flag reports |
| opnd_a | input | 40 | First operand |
| opnd_b | input | 40 | Second operand |
| res_q | output | 40 | Registered result |
| flag_q | output | 1 | Registered condition flag |

## Verification
The assertions assume that reset is high from time zero until the first clock edge has been seen. They also assume that every input is a known value on each edge where reset is low and the write enable is high. The bench meets both assumptions: it holds reset through the opening edges and drives every input from a task on the falling edge. It never leaves an input unknown once reset is released. Operands are chosen to reach each flag mode on both of its outcomes, including the two overflow boundary values and results of exactly zero.

// File: rtl/alu_dc_pkg.sv
package alu_dc_pkg;
  typedef logic [2:0] flag_sel_t;
  localparam flag_sel_t SEL_CARRY = 3'b000;
  localparam flag_sel_t SEL_NEG   = 3'b001;
  localparam flag_sel_t SEL_ZERO  = 3'b010;
  localparam flag_sel_t SEL_OVF   = 3'b011;
endpackage

// File: rtl/alu_dc_addsub.sv
module alu_dc_addsub #(
  parameter int DATA_W = 40
) (
  input  logic              sub,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic              cy_flag
);
  logic [DATA_W:0] ext;
  logic [DATA_W-1:0] b_eff;

  always_comb begin
    b_eff = sub ? ~b : b;
    ext = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, sub};
    sum = ext[DATA_W-1:0];
    // subtract: carry out high means no borrow
    cy_flag = sub ? ~ext[DATA_W] : ext[DATA_W];
  end
endmodule

// File: rtl/alu_dc_flagsel.sv
module alu_dc_flagsel
  import alu_dc_pkg::*;
#(
  parameter int DATA_W  = 40,
  parameter int GUARD_W = 8
) (
  input  flag_sel_t         sel,
  input  logic [DATA_W-1:0] sum,
  input  logic              cy_flag,
  output logic              flag
);
  localparam int REG_W = DATA_W - GUARD_W;
  localparam int OVF_W = GUARD_W + 1;

  logic [OVF_W-1:0] ovf_field;
  logic             ovf;

  always_comb begin
    ovf_field = sum[DATA_W-1:REG_W-1];
    ovf = !((&ovf_field) || !(|ovf_field));
    case (sel)
      SEL_NEG:  flag = sum[DATA_W-1];
      SEL_ZERO: flag = (sum == '0);
      SEL_OVF:  flag = ovf;
      default:  flag = cy_flag;
    endcase
  end
endmodule

// File: rtl/alu_dc_unit.sv
module alu_dc_unit
  import alu_dc_pkg::*;
#(
  parameter int DATA_W  = 40,
  parameter int GUARD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_we,
  input  logic              op_sub,
  input  logic [2:0]        flag_sel,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] res_q,
  output logic              flag_q
);
  logic [DATA_W-1:0] sum;
  logic              cy_flag;
  logic              flag_d;

  alu_dc_addsub #(.DATA_W(DATA_W)) u_addsub (
    .sub    (op_sub),
    .a      (opnd_a),
    .b      (opnd_b),
    .sum    (sum),
    .cy_flag(cy_flag)
  );

  alu_dc_flagsel #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_flagsel (
    .sel    (flag_sel_t'(flag_sel)),
    .sum    (sum),
    .cy_flag(cy_flag),
    .flag   (flag_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q  <= '0;
      flag_q <= 1'b0;
    end else if (op_we) begin
      res_q  <= sum;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/alu_dc_unit_chk.sv
module alu_dc_unit_chk #(
  parameter int DATA_W  = 40,
  parameter int GUARD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              op_we,
  input logic              op_sub,
  input logic [2:0]        flag_sel,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] res_q,
  input logic              flag_q
);
  localparam int REG_W = DATA_W - GUARD_W;

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (res_q == '0 && !flag_q));

  a_r2_add_result: assert property (@(posedge clk) disable iff (rst)
    (op_we && !op_sub) |=> res_q == DATA_W'($past(opnd_a) + $past(opnd_b)));

  a_r3_sub_result: assert property (@(posedge clk) disable iff (rst)
    (op_we && op_sub) |=> res_q == DATA_W'($past(opnd_a) - $past(opnd_b)));

  a_r4_neg_flag: assert property (@(posedge clk) disable iff (rst)
    (op_we && flag_sel == 3'b001) |=> flag_q == res_q[DATA_W-1]);

  a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
    (op_we && flag_sel == 3'b010) |=> flag_q == (res_q == '0));

  a_r6_ovf_flag: assert property (@(posedge clk) disable iff (rst)
    (op_we && flag_sel == 3'b011) |=>
      flag_q == ($countones(res_q[DATA_W-1:REG_W-1]) != 0 &&
                 $countones(res_q[DATA_W-1:REG_W-1]) != GUARD_W + 1));

  a_r8_borrow_flag: assert property (@(posedge clk) disable iff (rst)
    (op_we && op_sub && (flag_sel == 3'b000 || flag_sel[2])) |=>
      flag_q == ($past(opnd_a) < $past(opnd_b)));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !op_we |=> ($stable(res_q) && $stable(flag_q)));
endmodule

bind alu_dc_unit alu_dc_unit_chk #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_chk (
  .clk(clk), .rst(rst), .op_we(op_we), .op_sub(op_sub), .flag_sel(flag_sel),
  .opnd_a(opnd_a), .opnd_b(opnd_b), .res_q(res_q), .flag_q(flag_q)
);

// File: tb/alu_dc_unit_test.sv
`timescale 1ns/1ps
module alu_dc_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_we = 1'b0;
  logic        op_sub = 1'b0;
  logic [2:0]  flag_sel = 3'b000;
  logic [39:0] opnd_a = '0;
  logic [39:0] opnd_b = '0;
  logic [39:0] res_q;
  logic        flag_q;

  int checks = 0;
  int errors = 0;
  logic [39:0] exp_res = '0;
  logic        exp_flag = 1'b0;

  always #2.5 clk = ~clk;

  alu_dc_unit uut (
    .clk(clk), .rst(rst), .op_we(op_we), .op_sub(op_sub), .flag_sel(flag_sel),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .res_q(res_q), .flag_q(flag_q)
  );

  task automatic check(input string req, input logic [39:0] got_r,
                       input logic [39:0] want_r, input logic got_f,
                       input logic want_f);
    checks++;
    if (got_r !== want_r || got_f !== want_f) begin
      errors++;
      $display("FAIL %s: res=%h flag=%b expected res=%h flag=%b",
               req, got_r, got_f, want_r, want_f);
    end
  endtask

  // behavioural reference: called on a falling edge, checks on the next one
  task automatic step(input logic we, input logic sub, input logic [2:0] sel,
                      input logic [39:0] a, input logic [39:0] b);
    logic [40:0] wide;
    logic [39:0] r;
    logic        f;
    string       tag;
    op_we = we; op_sub = sub; flag_sel = sel; opnd_a = a; opnd_b = b;
    if (we) begin
      if (sub) begin
        r = a - b;
        tag = "R3";
      end else begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[39:0];
        tag = "R2";
      end
      case (sel)
        3'b001: begin f = r[39]; tag = {tag, "/R4"}; end
        3'b010: begin f = (r == 40'd0); tag = {tag, "/R5"}; end
        3'b011: begin
          f = !(r[39:31] == 9'h1FF || r[39:31] == 9'h000);
          tag = {tag, "/R6"};
        end
        default: begin
          if (sub) begin f = (a < b); tag = {tag, "/R8"}; end
          else begin wide = {1'b0, a} + {1'b0, b}; f = wide[40]; tag = {tag, "/R7"}; end
        end
      endcase
      exp_res = r;
      exp_flag = f;
    end else begin
      tag = "R9";
    end
    @(negedge clk);
    check(tag, res_q, exp_res, flag_q, exp_flag);
  endtask

  function automatic logic [39:0] sx32(input logic [31:0] v);
    return {{8{v[31]}}, v};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check("R1", res_q, 40'd0, flag_q, 1'b0);
    rst = 1'b0;

    // overflow boundaries
    step(1, 0, 3'b011, 40'hFF7FFFFFFE, 40'd1);   // 0xFF7FFFFFFF -> set
    step(1, 0, 3'b011, 40'hFF7FFFFFFF, 40'd1);   // 0xFF80000000 -> clear
    step(1, 0, 3'b011, 40'h007FFFFFFF, 40'd0);   // clear
    step(1, 0, 3'b011, 40'h007FFFFFFF, 40'd1);   // 0x0080000000 -> set
    step(1, 1, 3'b011, 40'h0000000000, 40'h0080000000);
    // negative mode
    step(1, 1, 3'b001, 40'd3, 40'd5);
    step(1, 0, 3'b001, 40'd3, 40'd5);
    // zero mode
    step(1, 1, 3'b010, 40'h123456789A, 40'h123456789A);
    step(1, 0, 3'b010, 40'hFFFFFFFFFF, 40'd1);
    step(1, 0, 3'b010, 40'hFFFFFFFFFF, 40'd2);
    // carry/borrow on every default code
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 3) continue;
      step(1, 0, 3'(c), 40'hFFFFFFFFFF, 40'd1);
      step(1, 0, 3'(c), 40'h7FFFFFFFFF, 40'd1);
      step(1, 1, 3'(c), 40'd4, 40'd9);
      step(1, 1, 3'(c), 40'd9, 40'd9);
    end
    // hold with changing inputs
    step(1, 0, 3'b011, 40'hFF7FFFFFFE, 40'd1);
    step(0, 1, 3'b010, 40'd7, 40'd7);
    step(0, 0, 3'b000, 40'hFFFFFFFFFF, 40'hFFFFFFFFFF);
    // random sign-extended and raw operands
    for (int i = 0; i < 400; i++) begin
      logic [39:0] ra, rb;
      if (i % 2 == 0) begin
        ra = sx32($urandom); rb = sx32($urandom);
      end else begin
        ra = {8'($urandom), 32'($urandom)}; rb = {8'($urandom), 32'($urandom)};
      end
      if (i % 7 == 0) rb = (i % 14 == 0) ? ra : -ra;
      step(($urandom % 5) != 0, 1'($urandom), 3'($urandom), ra, rb);
    end
    // reset in mid-run
    step(1, 0, 3'b000, 40'hFFFFFFFFFF, 40'd1);
    rst = 1'b1;
    @(negedge clk);
    exp_res = '0; exp_flag = 1'b0;
    check("R1", res_q, 40'd0, flag_q, 1'b0);
    rst = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule